// File: doc/BRIEF.md
# Grey-Scale Raster Scan-Out with 4x Enlargement

This block reads a packed 4-bit-per-pixel picture memory and turns it into a pixel stream for a 128 x 64 panel that is shown enlarged four times in each direction, giving 512 x 256 output pixels. Each memory byte carries two horizontally adjacent pixels. Each 4-bit level becomes either a 24-bit grey value (the same byte on all three channels) or a 16-bit 5-6-5 colour word. The format is chosen per frame by an input.

The picture memory holds more rows than the panel shows. Only the first `DISP_ROWS` rows are scanned. For each displayed row the block reads that row once into a local line store. It then replays the store for every repeated output line, so memory is never read while pixels are being sent. Output goes through a valid/ready handshake that carries start-of-frame and end-of-line flags. A frame is produced only when a redraw is pending. A one-cycle `invalidate` pulse requests a redraw.

Top module: `grey_scanout`

## Requirements
- R1: After reset `redraw_pending`, `px_valid` and `mem_rd` are low. No memory read and no pixel happen while no redraw is pending.
- R2: For display row r the block reads the `LINE_BYTES` addresses r*LINE_BYTES, r*LINE_BYTES+1, ... in increasing order, with read data returned one cycle after `mem_rd`. Each row is read exactly once per frame, rows in increasing order.
- R3: Within a byte, bits [7:4] are the left pixel and bits [3:0] are the right pixel.
- R4: Each source pixel is sent `MAG` times in a row.
- R5: Each output line is sent `MAG` times. No memory read happens while `px_valid` is high.
- R6: With grey format (`fmt_565`=0 at frame start), level i gives `px_data` = {g,g,g}, where g = 17*i.
- R7: With 5-6-5 format, n = 2i + (i>>3). `px_data[15:11]` = n, `px_data[10:5]` = 2n + (n>>4), `px_data[4:0]` = n, and `px_data[23:16]` = 0.
- R8: `px_sof` is high only on the first pixel of a frame. `px_eol` is high only on the last pixel of each output line.
- R9: While `px_valid` is high and `px_ready` is low, the pixel, its flags and the position all hold.
- R10: `redraw_pending` is set by `invalidate` and cleared when the last pixel of a frame is accepted. An `invalidate` that arrives after a frame has begun keeps it set, so another frame follows.
- R11: No address at or above DISP_ROWS*LINE_BYTES is ever read.
- R12: The output format is sampled when a frame starts. A change of `fmt_565` during a frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| invalidate | input | 1 | Redraw request pulse |
| fmt_565 | input | 1 | 1 selects 5-6-5 output, 0 selects 24-bit grey |
| mem_rd | output | 1 | Picture memory read strobe |
| mem_addr | output | ADDR_W | Picture memory byte address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| px_valid | output | 1 | Output pixel valid |
| px_ready | input | 1 | Sink accepts the pixel |
| px_data | output | 24 | Pixel value |
| px_sof | output | 1 | First pixel of a frame |
| px_eol | output | 1 | Last pixel of an output line |
| redraw_pending | output | 1 | A frame is requested or in progress |

## Verification
The assertions check on every cycle that a stalled pixel holds, that reads never overlap pixel output and never reach rows that are not displayed, that each format keeps its field structure, and that the pending flag only drops on an accepted end of line. Only the bench's scenarios show the ordering: nibble order, horizontal and vertical repetition, the exact address sequence and read count per frame, flag positions, the per-frame format latch, and a redraw requested during a frame producing a second one. These are swept over every pixel of a reduced panel with several memory patterns and stall patterns.

// File: rtl/grey_scanout_pkg.sv
// Shared types and colour expansion for the grey-scale scan-out.
// Assumes 4-bit source levels and a 24-bit output word.
package grey_scanout_pkg;

    typedef enum logic [1:0] {
        SCAN_IDLE  = 2'd0,
        SCAN_FETCH = 2'd1,
        SCAN_EMIT  = 2'd2
    } scan_state_e;

    // Widen a level to 8 bits and copy it onto three channels.
    function automatic logic [23:0] level_to_grey(input logic [3:0] lvl);
        logic [7:0] g;
        g = {lvl, lvl};
        return {g, g, g};
    endfunction

    // Build the 5-6-5 word: red and blue get n; green gets n with its top bit appended.
    function automatic logic [15:0] level_to_565(input logic [3:0] lvl);
        logic [4:0] n;
        n = {lvl, lvl[3]};
        return {n, n, n[4], n};
    endfunction

endpackage

// File: rtl/gso_linebuf.sv
// One source row of packed pixel bytes.
// Written during the fetch phase and read asynchronously during the emit phase.
// Holds no reset: its contents are always written before they are read.
module gso_linebuf #(
    parameter int LINE_BYTES = 64,
    localparam int BI_W = $clog2(LINE_BYTES)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [BI_W-1:0] widx,
    input  logic [7:0]      wdata,
    input  logic [BI_W-1:0] ridx,
    output logic [7:0]      rdata
);
    logic [7:0] store_q [LINE_BYTES];

    // Capture returned memory bytes.
    always_ff @(posedge clk) begin
        if (we) begin
            store_q[widx] <= wdata;
        end
    end

    // Present the byte holding the current pixel.
    always_comb begin
        rdata = store_q[ridx];
    end
endmodule

// File: rtl/gso_expand.sv
// Selects the nibble for the current pixel and expands it to the output format.
// Assumes the high nibble is the left pixel of the pair.
module gso_expand #(
    parameter bit WITH_565 = 1'b1
) (
    input  logic [7:0]  pair,
    input  logic        right,
    input  logic        fmt,
    output logic [23:0] pixel
);
    import grey_scanout_pkg::*;

    logic [3:0] lvl;

    // Pick the left (upper) or right (lower) nibble.
    always_comb begin
        lvl = right ? pair[3:0] : pair[7:4];
    end

    generate
        if (WITH_565) begin : g_both
            // Choose the 24-bit grey or the zero-padded 5-6-5 form.
            always_comb begin
                pixel = fmt ? {8'h00, level_to_565(lvl)} : level_to_grey(lvl);
            end
        end else begin : g_grey
            // Grey only; the format input is unused in this variant.
            logic unused_fmt;
            always_comb begin
                unused_fmt = fmt;
                pixel = level_to_grey(lvl);
            end
        end
    endgenerate
endmodule

// File: rtl/gso_ctrl.sv
// Frame sequencing: redraw request tracking, per-row fetch, and the
// four nested output counters (row, line repeat, pixel, pixel repeat).
// Assumes LINE_BYTES is a power of two, MAG >= 2 and DISP_ROWS >= 2.
// Memory returns data one cycle after a read strobe.
module gso_ctrl #(
    parameter int LINE_BYTES = 64,
    parameter int DISP_ROWS  = 64,
    parameter int MAG        = 4,
    parameter int ADDR_W     = 13,
    localparam int NPX   = 2 * LINE_BYTES,
    localparam int PX_W  = $clog2(NPX),
    localparam int BI_W  = $clog2(LINE_BYTES),
    localparam int RC_W  = $clog2(LINE_BYTES + 1),
    localparam int ROW_W = $clog2(DISP_ROWS),
    localparam int MAG_W = $clog2(MAG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              invalidate,
    input  logic              fmt_in,
    input  logic              px_ready,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              buf_we,
    output logic [BI_W-1:0]   buf_widx,
    output logic [BI_W-1:0]   buf_ridx,
    output logic              nib_right,
    output logic              px_valid,
    output logic              px_sof,
    output logic              px_eol,
    output logic              fmt_q,
    output logic              pending
);
    import grey_scanout_pkg::*;

    scan_state_e      state_q;
    logic [ROW_W-1:0] row_q;
    logic [MAG_W-1:0] ly_q;
    logic [PX_W-1:0]  px_q;
    logic [MAG_W-1:0] rx_q;
    logic [RC_W-1:0]  rd_cnt_q;
    logic             wr_vld_q;
    logic [BI_W-1:0]  wr_idx_q;
    logic             pend_q;
    logic             rearm_q;
    logic             fmt_r;

    logic last_rx, last_px, last_ly, last_row, accept, frame_end;

    // Position decode and the handshake.
    always_comb begin
        last_rx   = (rx_q == MAG_W'(MAG - 1));
        last_px   = (px_q == PX_W'(NPX - 1));
        last_ly   = (ly_q == MAG_W'(MAG - 1));
        last_row  = (row_q == ROW_W'(DISP_ROWS - 1));
        accept    = (state_q == SCAN_EMIT) && px_ready;
        frame_end = accept && last_rx && last_px && last_ly && last_row;
    end

    // Memory request and line-store write control.
    always_comb begin
        mem_rd   = (state_q == SCAN_FETCH) && (rd_cnt_q < RC_W'(LINE_BYTES));
        mem_addr = ADDR_W'(row_q) * ADDR_W'(LINE_BYTES) + ADDR_W'(rd_cnt_q);
        buf_we   = wr_vld_q;
        buf_widx = wr_idx_q;
    end

    // Output side of the stream.
    always_comb begin
        px_valid  = (state_q == SCAN_EMIT);
        buf_ridx  = px_q[PX_W-1:1];
        nib_right = px_q[0];
        px_sof    = px_valid && (row_q == '0) && (ly_q == '0) && (px_q == '0) && (rx_q == '0);
        px_eol    = px_valid && last_px && last_rx;
        fmt_q     = fmt_r;
        pending   = pend_q;
    end

    // Redraw request: set by invalidate, cleared at frame end unless re-armed mid-frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            rearm_q <= 1'b0;
        end else if (frame_end) begin
            pend_q  <= rearm_q | invalidate;
            rearm_q <= 1'b0;
        end else begin
            pend_q  <= pend_q | invalidate;
            rearm_q <= rearm_q | (invalidate && (state_q != SCAN_IDLE));
        end
    end

    // Delay the read strobe and index to line up with the returned data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_vld_q <= 1'b0;
            wr_idx_q <= '0;
        end else begin
            wr_vld_q <= mem_rd;
            wr_idx_q <= rd_cnt_q[BI_W-1:0];
        end
    end

    // Frame state machine and nested raster counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SCAN_IDLE;
            row_q    <= '0;
            ly_q     <= '0;
            px_q     <= '0;
            rx_q     <= '0;
            rd_cnt_q <= '0;
            fmt_r    <= 1'b0;
        end else begin
            case (state_q)
                SCAN_IDLE: begin
                    if (pend_q) begin
                        state_q  <= SCAN_FETCH;
                        row_q    <= '0;
                        rd_cnt_q <= '0;
                        fmt_r    <= fmt_in;
                    end
                end
                SCAN_FETCH: begin
                    if (mem_rd) begin
                        rd_cnt_q <= rd_cnt_q + 1'b1;
                    end
                    if (rd_cnt_q == RC_W'(LINE_BYTES)) begin
                        state_q <= SCAN_EMIT;
                        ly_q    <= '0;
                        px_q    <= '0;
                        rx_q    <= '0;
                    end
                end
                SCAN_EMIT: begin
                    if (accept) begin
                        rx_q <= last_rx ? '0 : rx_q + 1'b1;
                        if (last_rx) begin
                            px_q <= last_px ? '0 : px_q + 1'b1;
                            if (last_px) begin
                                ly_q <= last_ly ? '0 : ly_q + 1'b1;
                                if (last_ly) begin
                                    rd_cnt_q <= '0;
                                    if (last_row) begin
                                        state_q <= SCAN_IDLE;
                                    end else begin
                                        row_q   <= row_q + 1'b1;
                                        state_q <= SCAN_FETCH;
                                    end
                                end
                            end
                        end
                    end
                end
                default: state_q <= SCAN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/grey_scanout.sv
// Top level: sequencer, line store and colour expansion.
// Assumes a single-port picture memory with one cycle of read latency.
module grey_scanout #(
    parameter int LINE_BYTES = 64,
    parameter int DISP_ROWS  = 64,
    parameter int MEM_ROWS   = 80,
    parameter int MAG        = 4,
    parameter bit WITH_565   = 1'b1,
    localparam int ADDR_W = $clog2(MEM_ROWS * LINE_BYTES),
    localparam int BI_W   = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              invalidate,
    input  logic              fmt_565,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              px_valid,
    input  logic              px_ready,
    output logic [23:0]       px_data,
    output logic              px_sof,
    output logic              px_eol,
    output logic              redraw_pending
);
    logic            buf_we;
    logic [BI_W-1:0] buf_widx;
    logic [BI_W-1:0] buf_ridx;
    logic [7:0]      pair;
    logic            nib_right;
    logic            fmt_q;

    gso_ctrl #(
        .LINE_BYTES (LINE_BYTES),
        .DISP_ROWS  (DISP_ROWS),
        .MAG        (MAG),
        .ADDR_W     (ADDR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .invalidate (invalidate),
        .fmt_in     (fmt_565),
        .px_ready   (px_ready),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .buf_we     (buf_we),
        .buf_widx   (buf_widx),
        .buf_ridx   (buf_ridx),
        .nib_right  (nib_right),
        .px_valid   (px_valid),
        .px_sof     (px_sof),
        .px_eol     (px_eol),
        .fmt_q      (fmt_q),
        .pending    (redraw_pending)
    );

    gso_linebuf #(
        .LINE_BYTES (LINE_BYTES)
    ) u_line (
        .clk   (clk),
        .we    (buf_we),
        .widx  (buf_widx),
        .wdata (mem_rdata),
        .ridx  (buf_ridx),
        .rdata (pair)
    );

    gso_expand #(
        .WITH_565 (WITH_565)
    ) u_exp (
        .pair  (pair),
        .right (nib_right),
        .fmt   (fmt_q),
        .pixel (px_data)
    );
endmodule

// File: rtl/grey_scanout_chk.sv
// Property checker for grey_scanout, attached by bind.
module grey_scanout_chk #(
    parameter int LINE_BYTES = 64,
    parameter int DISP_ROWS  = 64,
    parameter int ADDR_W     = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              px_valid,
    input logic              px_ready,
    input logic [23:0]       px_data,
    input logic              px_sof,
    input logic              px_eol,
    input logic              redraw_pending,
    input logic              fmt_q
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !redraw_pending |-> (!mem_rd && !px_valid)); // R1
    AST_NO_FETCH_IN_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !px_valid); // R5
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (32'(mem_addr) < DISP_ROWS * LINE_BYTES)); // R11
    AST_GREY_CHANNELS: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && !fmt_q) |-> (px_data[23:16] == px_data[15:8] &&
                                  px_data[15:8] == px_data[7:0] &&
                                  px_data[7:4] == px_data[3:0])); // R6
    AST_565_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && fmt_q) |-> (px_data[23:16] == 8'h00 &&
                                 px_data[15:11] == px_data[4:0] &&
                                 px_data[10:6] == px_data[4:0])); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && !px_ready) |=> (px_valid && $stable(px_data) &&
                                     $stable(px_sof) && $stable(px_eol))); // R9
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(redraw_pending) |-> $past(px_valid && px_ready && px_eol)); // R10
    AST_SOF_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (px_sof || px_eol) |-> px_valid); // R8
endmodule

bind grey_scanout grey_scanout_chk #(
    .LINE_BYTES (LINE_BYTES),
    .DISP_ROWS  (DISP_ROWS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mem_rd         (mem_rd),
    .mem_addr       (mem_addr),
    .px_valid       (px_valid),
    .px_ready       (px_ready),
    .px_data        (px_data),
    .px_sof         (px_sof),
    .px_eol         (px_eol),
    .redraw_pending (redraw_pending),
    .fmt_q          (fmt_q)
);

// File: tb/grey_scanout_tb.sv
// Sweeps every output pixel of a reduced panel across formats, memory
// patterns and stall patterns; expected values come from arithmetic here.
module grey_scanout_tb;
    localparam int LB  = 8;
    localparam int DR  = 6;
    localparam int MR  = 8;
    localparam int MG  = 4;
    localparam int AW  = $clog2(MR * LB);
    localparam int NPX = 2 * LB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          invalidate = 1'b0;
    logic          fmt_565 = 1'b0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = 8'h00;
    logic          px_valid;
    logic          px_ready = 1'b1;
    logic [23:0]   px_data;
    logic          px_sof;
    logic          px_eol;
    logic          redraw_pending;

    int n_checks = 0;
    int n_fail   = 0;
    int seed     = 0;
    int exp_addr = 0;
    int rd_total = 0;
    int cyc      = 0;

    grey_scanout #(
        .LINE_BYTES (LB),
        .DISP_ROWS  (DR),
        .MEM_ROWS   (MR),
        .MAG        (MG)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .invalidate     (invalidate),
        .fmt_565        (fmt_565),
        .mem_rd         (mem_rd),
        .mem_addr       (mem_addr),
        .mem_rdata      (mem_rdata),
        .px_valid       (px_valid),
        .px_ready       (px_ready),
        .px_data        (px_data),
        .px_sof         (px_sof),
        .px_eol         (px_eol),
        .redraw_pending (redraw_pending)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] byte_at(input int a);
        return 8'(((a * 29) + (seed * 71) + 5) ^ (a >> 2));
    endfunction

    // Picture memory model, one cycle of latency.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= byte_at(int'(mem_addr));
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R2 / R11: address order of every read.
    always @(negedge clk) begin
        if (rst_n && mem_rd) begin
            chk(int'(mem_addr) == exp_addr, "R2 read address", 32'(mem_addr), 32'(exp_addr));
            chk(int'(mem_addr) < DR * LB, "R11 address range", 32'(mem_addr), 32'(DR * LB));
            exp_addr = (exp_addr + 1) % (DR * LB);
            rd_total++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    function automatic logic [23:0] exp_pixel(input int lvl, input bit f565);
        int n, g;
        if (f565) begin
            n = 2 * lvl + (lvl >> 3);
            return 24'((n << 11) | (((n << 1) | (n >> 4)) << 5) | n);
        end
        g = lvl * 17;
        return 24'(g * 65793);
    endfunction

    // Walk one full frame; check each pixel, optional stalls and mid-frame events.
    task automatic expect_frame(input bit f565, input bit stall, input bit flip, input bit inval_mid);
        int k = 0;
        for (int r = 0; r < DR; r++) begin
            for (int ly = 0; ly < MG; ly++) begin
                for (int p = 0; p < NPX; p++) begin
                    for (int rx = 0; rx < MG; rx++) begin
                        logic [7:0] b;
                        int lvl;
                        logic [23:0] e;
                        bit esof, eeol;
                        b    = byte_at(r * LB + p / 2);
                        lvl  = (p % 2 == 0) ? int'(b[7:4]) : int'(b[3:0]); // R3 left = upper
                        e    = exp_pixel(lvl, f565);
                        esof = (r == 0 && ly == 0 && p == 0 && rx == 0);
                        eeol = (p == NPX - 1 && rx == MG - 1);
                        if (flip && k == DR * MG * NPX * MG / 2) fmt_565 = ~f565;
                        invalidate = (inval_mid && k == 100);
                        while (!px_valid) @(negedge clk);
                        // R4 R5 R6 R7 R12: value at this raster position
                        chk(px_data == e, f565 ? "R7 R4 R5 pixel" : "R6 R4 R5 pixel", 32'(px_data), 32'(e));
                        chk(px_sof == esof && px_eol == eeol, "R8 flags", {px_sof, px_eol}, {esof, eeol});
                        if (stall && (k % 5 == 2)) begin
                            px_ready = 1'b0;
                            for (int s = 0; s < 2; s++) begin
                                @(negedge clk);
                                chk(px_valid && px_data == e && px_sof == esof && px_eol == eeol,
                                    "R9 stall hold", 32'(px_data), 32'(e));
                            end
                            px_ready = 1'b1;
                        end
                        @(negedge clk);
                        invalidate = 1'b0;
                        k++;
                    end
                end
            end
        end
    endtask

    task automatic pulse_inval();
        invalidate = 1'b1;
        @(negedge clk);
        invalidate = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!redraw_pending && !px_valid && !mem_rd, "R1 reset state",
            {redraw_pending, px_valid, mem_rd}, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!px_valid && !mem_rd, "R1 no frame without request", {px_valid, mem_rd}, 0);
        end

        // Grey, no stall.
        fmt_565 = 1'b0;
        pulse_inval();
        chk(redraw_pending, "R10 set by invalidate", 32'(redraw_pending), 1);
        expect_frame(1'b0, 1'b0, 1'b0, 1'b0);
        chk(!redraw_pending, "R10 cleared at frame end", 32'(redraw_pending), 0);
        chk(rd_total == DR * LB, "R2 reads per frame", 32'(rd_total), 32'(DR * LB));
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!px_valid && !mem_rd, "R1 idle after frame", {px_valid, mem_rd}, 0);
        end

        // 5-6-5 with stalls, new content.
        seed = 3;
        fmt_565 = 1'b1;
        pulse_inval();
        expect_frame(1'b1, 1'b1, 1'b0, 1'b0);
        chk(rd_total == 2 * DR * LB, "R2 reads per frame", 32'(rd_total), 32'(2 * DR * LB));

        // Grey with stalls; format input flips mid-frame; redraw re-armed mid-frame.
        seed = 9;
        fmt_565 = 1'b0;
        pulse_inval();
        expect_frame(1'b0, 1'b1, 1'b1, 1'b1); // R12
        chk(redraw_pending, "R10 re-armed during frame", 32'(redraw_pending), 1);
        // Second frame picks up the flipped format input (now 1).
        expect_frame(1'b1, 1'b0, 1'b0, 1'b0); // R12
        chk(!redraw_pending, "R10 cleared after repeat", 32'(redraw_pending), 0);
        chk(rd_total == 4 * DR * LB, "R2 reads per frame", 32'(rd_total), 32'(4 * DR * LB));

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule